// File: doc/BRIEF.md
# Multi-Mode Display Host Interface

This block is the slave-side front end of a display controller. A host microcontroller writes bytes to it over one of four buses, picked by two static strap inputs: SPI with a separate data/command pin (4-wire), SPI that carries the data/command flag in-band (3-wire), an 8-bit parallel bus with an enable strobe and a read/write select line (6800 style), or an 8-bit parallel bus with separate active-low read and write strobes (8080 style). The pins keep their physical positions in every mode, but their meaning changes with the mode.

Every host pin, the straps included, goes through a two-flop synchronizer into the system clock domain. Received bytes are tagged as command or display data and leave on a single internal write port with a one-cycle strobe. On the parallel buses the host can also read. The block then raises a one-cycle read request, drives a byte taken from an internal read port, and enables its data bus output only while the read condition holds.

Top module: `disp_host_if`

## Requirements
- R1: `mode_strap_i` = 2'b10 selects 3-wire SPI, 2'b00 selects 4-wire SPI, 2'b11 selects 6800-style parallel and 2'b01 selects 8080-style parallel. Bit 1 is the first strap and bit 0 the second. Bit 0 low means a serial mode.
- R2: While `host_cs_n_i` is high, no transfer in any mode produces `wr_stb_o` or `rd_stb_o`, and `host_d_oe_o` stays low.
- R3: A byte received with the data/command flag high leaves with `wr_is_data_o`=1, which marks display data. With the flag low it leaves with `wr_is_data_o`=0, which marks a command.
- R4: In 6800 mode, `host_en_rd_i` is an active-high enable. A write (`host_rw_wr_i`=0) is delivered once the enable falls, using the `host_d_i` and `host_dc_i` values held while it was high. With `host_rw_wr_i`=1 the cycle is a read.
- R5: In 8080 mode, `host_rw_wr_i` is an active-low write strobe. Its rising edge delivers the byte. `host_en_rd_i` is an active-low read strobe.
- R6: In 4-wire SPI, `host_d_i[0]` is the serial clock and `host_d_i[1]` the serial data. Bits shift in MSB first on the rising clock. `host_dc_i` is sampled with the eighth bit. The two parallel strobe pins have no effect in the serial modes.
- R7: In 3-wire SPI, a frame is 9 bits. The first bit is the data/command flag, the next 8 bits are the byte MSB first, and `host_dc_i` is ignored.
- R8: Raising chip select partway through a serial frame discards the partial bits. The next frame starts at bit 0.
- R9: During a parallel read, `host_d_oe_o` is high and `host_d_o` equals `rd_byte_i` only while the read condition holds, and `rd_stb_o` pulses once per read. At all other times, and always in the serial modes, the output is released.
- R10: While `rst_n` is low, the interface returns to idle: no strobes, output released, and partial serial bits dropped.
- R11: `wr_stb_o` is high for exactly one cycle for each delivered byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_strap_i | input | 2 | Bus mode straps |
| host_cs_n_i | input | 1 | Host chip select, active low |
| host_dc_i | input | 1 | Data (1) / command (0) select |
| host_en_rd_i | input | 1 | 6800 enable or 8080 read strobe |
| host_rw_wr_i | input | 1 | 6800 read/write select or 8080 write strobe |
| host_d_i | input | 8 | Host data bus in; bits 1:0 carry serial data and clock |
| host_d_o | output | 8 | Host data bus out during reads |
| host_d_oe_o | output | 1 | Host data bus output enable |
| wr_stb_o | output | 1 | One-cycle write strobe toward the core |
| wr_is_data_o | output | 1 | 1 = display data, 0 = command |
| wr_dat_o | output | 8 | Received byte |
| rd_stb_o | output | 1 | One-cycle read request toward the core |
| rd_byte_i | input | 8 | Byte returned to the host on a read |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and two synchronizer stages. With these values, the four modes share one pin set and can be switched between transfers. A random mix of writes and reads across all modes then reaches every decode path of the strobe pins. Directed cases cover the remaining corners: transfers with chip select high, strobe toggling in serial mode, serial frames cut short by chip select or by reset, and the 3-wire in-band flag set opposite to the data/command pin.

// File: rtl/disp_if_pkg.sv
package disp_if_pkg;

    localparam int HOST_DW = 8;

    typedef enum logic [1:0] {
        MODE_SPI4  = 2'b00,
        MODE_P8080 = 2'b01,
        MODE_SPI3  = 2'b10,
        MODE_P6800 = 2'b11
    } host_mode_e;

    typedef struct packed {
        logic               stb;
        logic               is_data;
        logic [HOST_DW-1:0] dat;
    } wr_beat_t;

endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dhi_serial_rx.sv
module dhi_serial_rx
    import disp_if_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     three_wire_i,
    input  logic     cs_n_i,
    input  logic     sclk_i,
    input  logic     sdin_i,
    input  logic     dc_i,
    output wr_beat_t beat_o
);

    localparam int CNT_W = $clog2(HOST_DW + 2);

    typedef struct packed {
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [HOST_DW:0] sr;
        wr_beat_t         beat;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic [CNT_W-1:0] last_bit;
    logic [HOST_DW:0] shifted;

    always_comb begin
        st_d            = st_q;
        st_d.beat.stb   = 1'b0;
        st_d.sclk_prev  = sclk_i;
        last_bit        = three_wire_i ? CNT_W'(HOST_DW) : CNT_W'(HOST_DW - 1);
        shifted         = {st_q.sr[HOST_DW-1:0], sdin_i};
        if (!en_i || cs_n_i) begin
            st_d.cnt = '0;
        end else if (sclk_i && !st_q.sclk_prev) begin
            st_d.sr = shifted;
            if (st_q.cnt == last_bit) begin
                st_d.cnt          = '0;
                st_d.beat.stb     = 1'b1;
                st_d.beat.is_data = three_wire_i ? shifted[HOST_DW] : dc_i;
                st_d.beat.dat     = shifted[HOST_DW-1:0];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_o = st_q.beat;

    AST_SER_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(HOST_DW)); // R7
    AST_SER_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (st_q.cnt == '0) && !beat_o.stb); // R8

endmodule

// File: rtl/dhi_par_rx.sv
module dhi_par_rx
    import disp_if_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               m6800_i,
    input  logic               cs_n_i,
    input  logic               en_rd_i,
    input  logic               rw_wr_i,
    input  logic               dc_i,
    input  logic [HOST_DW-1:0] d_i,
    output wr_beat_t           beat_o,
    output logic               rd_act_o,
    output logic               rd_stb_o
);

    typedef struct packed {
        logic               wr_act;
        logic               rd_act;
        logic               rd_stb;
        logic               hold_dc;
        logic [HOST_DW-1:0] hold_d;
        wr_beat_t           beat;
    } par_st_t;

    par_st_t st_d, st_q;
    logic    wr_cond, rd_cond;

    always_comb begin
        if (m6800_i) begin
            wr_cond = en_rd_i && !rw_wr_i;
            rd_cond = en_rd_i && rw_wr_i;
        end else begin
            wr_cond = !rw_wr_i;
            rd_cond = !en_rd_i && rw_wr_i;
        end
        wr_cond = wr_cond && en_i && !cs_n_i;
        rd_cond = rd_cond && en_i && !cs_n_i;

        st_d          = st_q;
        st_d.wr_act   = wr_cond;
        st_d.rd_act   = rd_cond;
        st_d.rd_stb   = rd_cond && !st_q.rd_act;
        st_d.beat.stb = 1'b0;
        if (wr_cond) begin
            st_d.hold_dc = dc_i;
            st_d.hold_d  = d_i;
        end
        if (st_q.wr_act && !wr_cond) begin
            st_d.beat.stb     = 1'b1;
            st_d.beat.is_data = st_q.hold_dc;
            st_d.beat.dat     = st_q.hold_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_o   = st_q.beat;
    assign rd_act_o = st_q.rd_act;
    assign rd_stb_o = st_q.rd_stb;

    AST_PAR_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_o.stb |-> !$past(cs_n_i, 2)); // R2
    AST_PAR_OFF_IN_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rd_act_o && !rd_stb_o); // R9

endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
    import disp_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_strap_i,
    input  logic               host_cs_n_i,
    input  logic               host_dc_i,
    input  logic               host_en_rd_i,
    input  logic               host_rw_wr_i,
    input  logic [HOST_DW-1:0] host_d_i,
    output logic [HOST_DW-1:0] host_d_o,
    output logic               host_d_oe_o,
    output logic               wr_stb_o,
    output logic               wr_is_data_o,
    output logic [HOST_DW-1:0] wr_dat_o,
    output logic               rd_stb_o,
    input  logic [HOST_DW-1:0] rd_byte_i
);

    localparam int PIN_W = HOST_DW + 6;
    localparam logic [PIN_W-1:0] PIN_IDLE = PIN_W'(1) << (HOST_DW + 3);

    typedef struct packed {
        wr_beat_t           wr;
        logic               oe;
        logic [HOST_DW-1:0] dout;
        logic               rd_stb;
    } top_st_t;

    logic [PIN_W-1:0]   pins_a, pins_s;
    logic [1:0]         strap_s;
    logic               cs_n_s, dc_s, en_rd_s, rw_wr_s;
    logic [HOST_DW-1:0] d_s;
    host_mode_e         mode;
    logic               is_serial, is_3wire, is_6800;
    wr_beat_t           ser_beat, par_beat;
    logic               par_rd_act, par_rd_stb;
    top_st_t            st_d, st_q;

    assign pins_a = {mode_strap_i, host_cs_n_i, host_dc_i, host_en_rd_i, host_rw_wr_i, host_d_i};

    dhi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_a),
        .sync_o  (pins_s)
    );

    assign {strap_s, cs_n_s, dc_s, en_rd_s, rw_wr_s, d_s} = pins_s;

    assign mode      = host_mode_e'(strap_s);
    assign is_serial = (mode == MODE_SPI4) || (mode == MODE_SPI3);
    assign is_3wire  = (mode == MODE_SPI3);
    assign is_6800   = (mode == MODE_P6800);

    dhi_serial_rx i_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (is_serial),
        .three_wire_i (is_3wire),
        .cs_n_i       (cs_n_s),
        .sclk_i       (d_s[0]),
        .sdin_i       (d_s[1]),
        .dc_i         (dc_s),
        .beat_o       (ser_beat)
    );

    dhi_par_rx i_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (!is_serial),
        .m6800_i  (is_6800),
        .cs_n_i   (cs_n_s),
        .en_rd_i  (en_rd_s),
        .rw_wr_i  (rw_wr_s),
        .dc_i     (dc_s),
        .d_i      (d_s),
        .beat_o   (par_beat),
        .rd_act_o (par_rd_act),
        .rd_stb_o (par_rd_stb)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr     = ser_beat.stb ? ser_beat : par_beat;
        st_d.oe     = par_rd_act;
        st_d.dout   = par_rd_act ? rd_byte_i : '0;
        st_d.rd_stb = par_rd_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb_o     = st_q.wr.stb;
    assign wr_is_data_o = st_q.wr.is_data;
    assign wr_dat_o     = st_q.wr.dat;
    assign host_d_oe_o  = st_q.oe;
    assign host_d_o     = st_q.dout;
    assign rd_stb_o     = st_q.rd_stb;

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R11
    AST_RD_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> host_d_oe_o); // R9
    AST_NO_DUAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_beat.stb && par_beat.stb)); // R1
    AST_DOUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_d_oe_o |-> host_d_o == '0); // R9

endmodule

// File: tb/test_disp_host_if.sv
module test_disp_host_if;

    localparam int CLK_P = 10;
    localparam int WDOG  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_strap = 2'b00;
    logic       cs_n = 1'b1, dc = 1'b0, en_rd = 1'b0, rw_wr = 1'b0;
    logic [7:0] d_in = '0, rd_byte = '0;
    logic [7:0] d_out, wr_dat;
    logic       d_oe, wr_stb, wr_is_data, rd_stb;

    int checks = 0, failures = 0;
    int wr_total = 0, rd_total = 0, cyc = 0;
    logic [8:0] wr_last = '0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    disp_host_if i_disp_host_if (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap_i (mode_strap),
        .host_cs_n_i  (cs_n),
        .host_dc_i    (dc),
        .host_en_rd_i (en_rd),
        .host_rw_wr_i (rw_wr),
        .host_d_i     (d_in),
        .host_d_o     (d_out),
        .host_d_oe_o  (d_oe),
        .wr_stb_o     (wr_stb),
        .wr_is_data_o (wr_is_data),
        .wr_dat_o     (wr_dat),
        .rd_stb_o     (rd_stb),
        .rd_byte_i    (rd_byte)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_stb) begin
            wr_total <= wr_total + 1;
            wr_last  <= {wr_is_data, wr_dat};
        end
        if (rd_stb) rd_total <= rd_total + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [8:0] expect_beat(input logic is_data, input logic [7:0] b);
        return {is_data, b};
    endfunction

    function automatic logic is_par(input logic [1:0] m);
        return m[0];
    endfunction

    task automatic go_mode(input logic [1:0] m);
        cs_n = 1'b1;
        d_in = '0;
        mode_strap = m;
        if (m == 2'b01) begin en_rd = 1'b1; rw_wr = 1'b1; end
        else            begin en_rd = 1'b0; rw_wr = 1'b0; end
        clks(6);
    endtask

    task automatic ser_bit(input logic b);
        d_in[1] = b; d_in[0] = 1'b0; clks(3);
        d_in[0] = 1'b1; clks(3);
        d_in[0] = 1'b0;
    endtask

    task automatic ser_frame(input logic three, input logic dcv, input logic [7:0] b,
                             input int nbits, input logic csv);
        cs_n = csv; dc = three ? ~dcv : dcv; clks(3);
        if (three) ser_bit(dcv);
        for (int i = 7; i >= 0; i--) if (7 - i < nbits) ser_bit(b[i]);
        clks(3); cs_n = 1'b1; clks(8);
    endtask

    task automatic par_write(input logic m6800, input logic dcv, input logic [7:0] b,
                             input logic csv);
        cs_n = csv; dc = dcv; d_in = b; clks(3);
        if (m6800) begin rw_wr = 1'b0; en_rd = 1'b1; clks(4); en_rd = 1'b0; end
        else       begin rw_wr = 1'b0; clks(4); rw_wr = 1'b1; end
        clks(3); cs_n = 1'b1; clks(6);
    endtask

    task automatic par_read(input logic m6800, input logic [7:0] rb, input string req);
        int base_r = rd_total;
        int base_w = wr_total;
        rd_byte = rb; cs_n = 1'b0; clks(2);
        if (m6800) begin rw_wr = 1'b1; en_rd = 1'b1; end
        else       begin en_rd = 1'b0; end
        clks(8);
        chk(d_oe === 1'b1, {req, " R9 oe during read"}, d_oe, 1);
        chk(d_out === rb, {req, " R9 read byte"}, d_out, rb);
        if (m6800) en_rd = 1'b0; else en_rd = 1'b1;
        clks(6);
        chk(d_oe === 1'b0, {req, " R9 released after read"}, d_oe, 0);
        chk(rd_total - base_r == 1, {req, " R9 one read request"}, rd_total - base_r, 1);
        chk(wr_total == base_w, {req, " read made no write"}, wr_total - base_w, 0);
        cs_n = 1'b1; rw_wr = m6800 ? 1'b0 : 1'b1; clks(4);
    endtask

    task automatic expect_one(input logic [8:0] e, input string req);
        chk(wr_total == 1, {req, " one write delivered"}, wr_total, 1);
        chk(wr_last == e, {req, " write value"}, wr_last, e);
    endtask

    initial begin
        int base;
        logic [7:0] b;
        logic       dv;
        logic [1:0] m;
        void'($urandom(32'h1D5C_0A7E));
        clks(4);
        // R10: reset state
        chk(d_oe === 1'b0, "R10 oe in reset", d_oe, 0);
        chk(wr_stb === 1'b0, "R10 wr_stb in reset", wr_stb, 0);
        chk(rd_stb === 1'b0, "R10 rd_stb in reset", rd_stb, 0);
        rst_n = 1'b1; clks(4);

        // R6 R3: 4-wire SPI data byte
        go_mode(2'b00); base = wr_total;
        ser_frame(1'b0, 1'b1, 8'hA5, 8, 1'b0);
        chk(wr_total - base == 1, "R6 spi4 count", wr_total - base, 1);
        chk(wr_last == expect_beat(1'b1, 8'hA5), "R6 R3 spi4 data", wr_last, 9'h1A5);

        // R7: 3-wire with in-band command flag, dc pin opposite
        go_mode(2'b10); base = wr_total;
        ser_frame(1'b1, 1'b0, 8'h3C, 8, 1'b0);
        chk(wr_total - base == 1, "R7 spi3 count", wr_total - base, 1);
        chk(wr_last == expect_beat(1'b0, 8'h3C), "R7 R3 spi3 cmd", wr_last, 9'h03C);

        // R8: abort partway, then full frame
        go_mode(2'b00); base = wr_total;
        ser_frame(1'b0, 1'b0, 8'hFF, 5, 1'b0);
        chk(wr_total == base, "R8 partial frame dropped", wr_total - base, 0);
        ser_frame(1'b0, 1'b0, 8'h81, 8, 1'b0);
        chk(wr_total - base == 1 && wr_last == 9'h081, "R8 frame after abort", wr_last, 9'h081);

        // R10: reset in the middle of a serial frame
        go_mode(2'b10); base = wr_total;
        cs_n = 1'b0; clks(3);
        for (int i = 0; i < 4; i++) ser_bit(1'b1);
        rst_n = 1'b0; clks(3); rst_n = 1'b1; clks(3);
        cs_n = 1'b1; clks(6);
        ser_frame(1'b1, 1'b1, 8'h42, 8, 1'b0);
        chk(wr_total - base == 1 && wr_last == 9'h142, "R10 frame after reset", wr_last, 9'h142);

        // R2: chip select high in every mode
        base = wr_total;
        go_mode(2'b00); ser_frame(1'b0, 1'b1, 8'h55, 8, 1'b1);
        go_mode(2'b10); ser_frame(1'b1, 1'b1, 8'h55, 8, 1'b1);
        go_mode(2'b11); par_write(1'b1, 1'b1, 8'h55, 1'b1);
        go_mode(2'b01); par_write(1'b0, 1'b1, 8'h55, 1'b1);
        chk(wr_total == base, "R2 no write with cs high", wr_total - base, 0);
        base = rd_total;
        cs_n = 1'b1; en_rd = 1'b0; clks(8);
        chk(d_oe === 1'b0, "R2 no read with cs high", d_oe, 0);
        chk(rd_total == base, "R2 no read request", rd_total - base, 0);
        en_rd = 1'b1; clks(4);

        // R6: strobe pins ignored in serial mode
        go_mode(2'b00); base = wr_total;
        cs_n = 1'b0; clks(2);
        for (int i = 0; i < 3; i++) begin
            en_rd = 1'b1; rw_wr = 1'b1; clks(4);
            en_rd = 1'b0; clks(4); rw_wr = 1'b0; clks(4);
        end
        en_rd = 1'b1; rw_wr = 1'b1; clks(6);
        chk(d_oe === 1'b0, "R6 R9 no output in serial", d_oe, 0);
        en_rd = 1'b0; rw_wr = 1'b0; cs_n = 1'b1; clks(6);
        chk(wr_total == base, "R6 strobes ignored in serial", wr_total - base, 0);

        // R4 R5: directed parallel writes and reads
        go_mode(2'b11); base = wr_total;
        par_write(1'b1, 1'b0, 8'h00, 1'b0);
        chk(wr_total - base == 1 && wr_last == 9'h000, "R4 6800 cmd write", wr_last, 9'h000);
        par_read(1'b1, 8'hC3, "R4 6800");
        go_mode(2'b01); base = wr_total;
        par_write(1'b0, 1'b1, 8'hFF, 1'b0);
        chk(wr_total - base == 1 && wr_last == 9'h1FF, "R5 8080 data write", wr_last, 9'h1FF);
        par_read(1'b0, 8'h5A, "R5 8080");

        // R1 R11: random mix over all modes
        for (int n = 0; n < 60; n++) begin
            m  = 2'($urandom % 4);
            b  = 8'($urandom);
            dv = 1'($urandom);
            go_mode(m);
            if (is_par(m) && ($urandom % 4 == 0)) begin
                par_read(m[1], b, "R1 random");
            end else begin
                base = wr_total;
                if (is_par(m)) par_write(m[1], dv, b, 1'b0);
                else           ser_frame(m[1], dv, b, 8, 1'b0);
                chk(wr_total - base == 1, "R1 R11 random write count", wr_total - base, 1);
                chk(wr_last == expect_beat(dv, b), "R1 R3 random write value",
                    wr_last, expect_beat(dv, b));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (cyc < WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule